// File: doc/BRIEF.md
# Fourteen-Clock Oversampled UART Controller

This block is a memory-mapped serial port whose bit period is always fourteen sample clocks long, each sample clock being one or more cycles of the system clock. A single data address serves both directions: a write queues a byte for transmission, and a read takes the oldest received entry. Each received entry carries its own status flags. Alongside the data port sit a FIFO level view, an interrupt identification view, a control word and an 8-bit rate divider.

The receiver locks onto the falling edge of a start bit. It then samples every bit once, at a programmable position within the fourteen-clock bit period. Frames with a low stop bit are marked as framing errors, and all-zero frames with a low stop bit are also marked as breaks. Trigger levels, the idle timeout and the flow-control thresholds are chosen from small fixed tables. Optional hardware flow control gates the transmitter on a clear-to-send input and drives a ready-to-receive output from the receive FIFO fill.

Top module: `osr14_uart`

## Requirements
- R1: A transmitted frame is one low start bit, eight data bits least significant first, then one high stop bit. Each bit lasts 14 × (RATE + 1) clocks, where RATE is the value written at address 4.
- R2: A write to address 0 pushes bits 7:0 into the TX FIFO. A write while the TX FIFO is full is dropped. Address 1 reads the TX FIFO occupancy in bits 15:8 and the RX FIFO occupancy in bits 7:0.
- R3: The receiver samples each bit at in-period count min(OFFSET, 13), where OFFSET is control bits 13:9. A read of address 0 pops the RX FIFO and returns the data in bits 7:0, an empty flag in bit 8, a framing-error flag in bit 9 and a break flag in bit 10. An empty read returns only bit 8 set.
- R4: A frame with a low stop bit sets the word's bit 9 and the sticky status bit 3 at address 2. If its data is also zero, it additionally sets the word's bit 10 and the sticky status bit 4.
- R5: A frame that arrives while the RX FIFO is full is discarded, the stored entries are kept, and sticky status bit 5 is set.
- R6: Writing a one to bit 6, 5, 4 or 3 of address 2 clears that sticky bit. Zeros leave them unchanged.
- R7: Status bit 1 is high while RX occupancy is at least the level selected by control bits 4:2 (codes 0..5 select 1, 4, 8, 16, 32, 48).
- R8: Status bit 0 is high while TX occupancy is at most the level selected by control bits 1:0 (codes 0..3 select 0, 4, 8, 16). Sticky status bit 6 sets when a transmit pop brings occupancy down to that level.
- R9: Status bit 2 is high when control bits 17:16 are nonzero, the RX FIFO is not empty, and no RX push or pop has happened for 40, 80 or 160 bit periods (codes 1, 2, 3).
- R10: irq = (ctrl bit 5 AND status bit 6) OR (ctrl bit 6 AND (status bit 1 OR status bit 2)) OR (ctrl bit 7 AND (status bit 3, 4 or 5)).
- R11: With control bit 14 set, a new frame starts only while cts_in XOR control bit 15 is 1. With bit 14 clear, frames start freely.
- R12: With control bit 18 set, rts_out = (RX occupancy < level from bits 20:19, codes 0..3 selecting 8, 16, 32, 48) XOR bit 21. With bit 18 clear, rts_out is 1.
- R13: While control bit 8 is set, txd is held low.
- R14: After reset, txd and rts_out are 1, irq is 0, both occupancies are 0, address 2 reads 0x01 and address 0 reads 0x100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address (0 data, 1 level, 2 status, 3 control, 4 rate) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| irq | output | 1 | Combined interrupt request |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| cts_in | input | 1 | Clear-to-send input |
| rts_out | output | 1 | Ready-to-receive output |

## Verification
The bench builds the block with an 8-entry FIFO depth. That makes TX drop-on-full, RX overrun and the ready-to-receive threshold of 8 reachable within a few hundred bit periods. Most traffic runs at RATE 0, where a bit is 14 clocks. That lets the bench shape bits whose level changes part-way through, so different sample offsets read opposite data. One burst at RATE 1 confirms that the bit period scales with the divider.

// File: rtl/osr14_pkg.sv
package osr14_pkg;
  localparam int RATE_W  = 8;
  localparam int LVL_W   = 8;
  localparam int OSR     = 14;
  localparam int CTRL_W  = 22;

  localparam logic [2:0] ADR_DATA  = 3'd0;
  localparam logic [2:0] ADR_LEVEL = 3'd1;
  localparam logic [2:0] ADR_STAT  = 3'd2;
  localparam logic [2:0] ADR_CTRL  = 3'd3;
  localparam logic [2:0] ADR_RATE  = 3'd4;

  // control word field positions
  localparam int CB_TXI   = 5;
  localparam int CB_RXI   = 6;
  localparam int CB_ERRI  = 7;
  localparam int CB_BRK   = 8;
  localparam int CB_OFF   = 9;
  localparam int CB_CTSEN = 14;
  localparam int CB_CTSIV = 15;
  localparam int CB_TMO   = 16;
  localparam int CB_RTSEN = 18;
  localparam int CB_RTSTH = 19;
  localparam int CB_RTSIV = 21;

  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic [7:0] data;
  } rx_word_t;

  function automatic logic [LVL_W-1:0] rx_trig_of(input logic [2:0] code);
    case (code)
      3'd0:    rx_trig_of = 8'd1;
      3'd1:    rx_trig_of = 8'd4;
      3'd2:    rx_trig_of = 8'd8;
      3'd3:    rx_trig_of = 8'd16;
      3'd4:    rx_trig_of = 8'd32;
      default: rx_trig_of = 8'd48;
    endcase
  endfunction

  function automatic logic [LVL_W-1:0] tx_trig_of(input logic [1:0] code);
    case (code)
      2'd0:    tx_trig_of = 8'd0;
      2'd1:    tx_trig_of = 8'd4;
      2'd2:    tx_trig_of = 8'd8;
      default: tx_trig_of = 8'd16;
    endcase
  endfunction

  function automatic logic [LVL_W-1:0] rts_thr_of(input logic [1:0] code);
    case (code)
      2'd0:    rts_thr_of = 8'd8;
      2'd1:    rts_thr_of = 8'd16;
      2'd2:    rts_thr_of = 8'd32;
      default: rts_thr_of = 8'd48;
    endcase
  endfunction

  // idle limit in bit periods (ten bit periods per character)
  function automatic logic [7:0] tmo_lim_of(input logic [1:0] code);
    case (code)
      2'd1:    tmo_lim_of = 8'd40;
      2'd2:    tmo_lim_of = 8'd80;
      2'd3:    tmo_lim_of = 8'd160;
      default: tmo_lim_of = 8'd0;
    endcase
  endfunction
endpackage

// File: rtl/osr14_fifo.sv
module osr14_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [WIDTH-1:0]           din,
  input  logic                       pop,
  output logic [WIDTH-1:0]           dout,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       full,
  output logic                       empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             wr_ok, rd_ok;

  always_comb begin
    wr_ok  = push && (cnt_q != CW'(DEPTH));
    rd_ok  = pop && (cnt_q != '0);
    wptr_d = wr_ok ? wptr_q + AW'(1) : wptr_q;
    rptr_d = rd_ok ? rptr_q + AW'(1) : rptr_q;
    cnt_d  = cnt_q + CW'(wr_ok) - CW'(rd_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem_q[wptr_q] <= din;
  end

  assign dout  = mem_q[rptr_q];
  assign count = cnt_q;
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);

  AST_FIFO_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> $stable(cnt_q)); // R2
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (cnt_q == '0)); // R3
endmodule

// File: rtl/osr14_tx.sv
module osr14_tx
  import osr14_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate,
  input  logic              permit,
  input  logic              has_data,
  input  logic [7:0]        data,
  output logic              pop,
  output logic              line,
  output logic              bit_stb
);
  logic [RATE_W-1:0] pre_q, pre_d;
  logic [3:0]        ph_q, ph_d;
  logic [9:0]        sh_q, sh_d;
  logic [3:0]        left_q, left_d;
  logic              pre_wrap, load;

  always_comb begin
    pre_wrap = (pre_q >= rate);
    bit_stb  = pre_wrap && (ph_q == 4'(OSR - 1));
    pre_d    = pre_wrap ? '0 : pre_q + RATE_W'(1);
    ph_d     = ph_q;
    if (pre_wrap) ph_d = (ph_q == 4'(OSR - 1)) ? 4'd0 : ph_q + 4'd1;
    load   = bit_stb && (left_q <= 4'd1) && has_data && permit;
    sh_d   = sh_q;
    left_d = left_q;
    if (bit_stb) begin
      if (load) begin
        sh_d   = {1'b1, data, 1'b0};
        left_d = 4'd10;
      end else if (left_q != 4'd0) begin
        sh_d   = {1'b1, sh_q[9:1]};
        left_d = left_q - 4'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      ph_q   <= '0;
      sh_q   <= '1;
      left_q <= '0;
    end else begin
      pre_q  <= pre_d;
      ph_q   <= ph_d;
      sh_q   <= sh_d;
      left_q <= left_d;
    end
  end

  assign pop  = load;
  assign line = (left_q != 4'd0) ? sh_q[0] : 1'b1;

  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (line == 1'b0)); // R1
  AST_TX_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (left_q == 4'd1) |-> (line == 1'b1)); // R1
endmodule

// File: rtl/osr14_rx.sv
module osr14_rx
  import osr14_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic [RATE_W-1:0] rate,
  input  logic [4:0]        offset,
  output logic              frame_vld,
  output rx_word_t          frame
);
  logic              s1_q, s2_q, s3_q;
  logic              busy_q, busy_d;
  logic [RATE_W-1:0] pre_q, pre_d;
  logic [3:0]        ph_q, ph_d, bit_q, bit_d, off_eff;
  logic [7:0]        sh_q, sh_d;
  logic              vld_q, vld_d;
  rx_word_t          frm_q, frm_d;
  logic              fall, samp;

  always_comb begin
    off_eff = (offset > 5'd13) ? 4'd13 : offset[3:0];
    fall    = s3_q && !s2_q;
    samp    = busy_q && (pre_q == '0) && (ph_q == off_eff);
    busy_d  = busy_q;
    pre_d   = pre_q;
    ph_d    = ph_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    vld_d   = 1'b0;
    frm_d   = frm_q;
    if (!busy_q) begin
      if (fall) begin
        busy_d = 1'b1;
        pre_d  = '0;
        ph_d   = '0;
        bit_d  = '0;
      end
    end else begin
      if (pre_q >= rate) begin
        pre_d = '0;
        if (ph_q == 4'(OSR - 1)) begin
          ph_d  = '0;
          bit_d = bit_q + 4'd1;
        end else begin
          ph_d = ph_q + 4'd1;
        end
      end else begin
        pre_d = pre_q + RATE_W'(1);
      end
      if (samp) begin
        if (bit_q == 4'd0) begin
          if (s2_q) busy_d = 1'b0;           // false start
        end else if (bit_q <= 4'd8) begin
          sh_d = {s2_q, sh_q[7:1]};
        end else begin
          busy_d     = 1'b0;
          vld_d      = 1'b1;
          frm_d.data = sh_q;
          frm_d.ferr = !s2_q;
          frm_d.brk  = !s2_q && (sh_q == 8'd0);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      s3_q   <= 1'b1;
      busy_q <= 1'b0;
      pre_q  <= '0;
      ph_q   <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      vld_q  <= 1'b0;
      frm_q  <= '0;
    end else begin
      s1_q   <= rxd;
      s2_q   <= s1_q;
      s3_q   <= s2_q;
      busy_q <= busy_d;
      pre_q  <= pre_d;
      ph_q   <= ph_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      vld_q  <= vld_d;
      frm_q  <= frm_d;
    end
  end

  assign frame_vld = vld_q;
  assign frame     = frm_q;

  AST_RX_SINGLE_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld |=> !frame_vld); // R3
  AST_RX_BRK_IS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && frame.brk) |-> (frame.ferr && frame.data == 8'd0)); // R4
endmodule

// File: rtl/osr14_uart.sv
module osr14_uart
  import osr14_pkg::*;
#(
  parameter int FIFO_DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        txd,
  input  logic        rxd,
  input  logic        cts_in,
  output logic        rts_out
);
  localparam int CW = $clog2(FIFO_DEPTH) + 1;

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [RATE_W-1:0] rate_q, rate_d;
  logic txs_q, txs_d, ovr_q, ovr_d, brk_q, brk_d, fe_q, fe_d;
  logic [7:0] idle_q, idle_d;

  logic wr_data, rd_data, wr_ctrl, wr_rate, wr_stat;
  logic [7:0] tx_dout;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic tx_full, tx_empty, rx_full, rx_empty, tx_pop, tx_line, bit_stb;
  logic frame_vld;
  rx_word_t frame, rx_dout;
  logic [LVL_W-1:0] tx_lvl, rx_lvl;
  logic tx_trig_hit, rx_trig_hit, tmo_hit, ovr_set, tx_set, permit;
  logic [6:0] stat;

  always_comb begin
    wr_data = bus_sel && bus_wr && (bus_addr == ADR_DATA);
    rd_data = bus_sel && !bus_wr && (bus_addr == ADR_DATA);
    wr_stat = bus_sel && bus_wr && (bus_addr == ADR_STAT);
    wr_ctrl = bus_sel && bus_wr && (bus_addr == ADR_CTRL);
    wr_rate = bus_sel && bus_wr && (bus_addr == ADR_RATE);
  end

  osr14_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(wr_data), .din(bus_wdata[7:0]),
    .pop(tx_pop), .dout(tx_dout), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

  osr14_fifo #(.WIDTH($bits(rx_word_t)), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(frame_vld), .din(frame),
    .pop(rd_data), .dout(rx_dout), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

  osr14_tx u_tx (
    .clk(clk), .rst_n(rst_n), .rate(rate_q), .permit(permit),
    .has_data(!tx_empty), .data(tx_dout), .pop(tx_pop), .line(tx_line),
    .bit_stb(bit_stb));

  osr14_rx u_rx (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .rate(rate_q),
    .offset(ctrl_q[CB_OFF +: 5]), .frame_vld(frame_vld), .frame(frame));

  always_comb begin
    tx_lvl      = LVL_W'(tx_cnt);
    rx_lvl      = LVL_W'(rx_cnt);
    permit      = !ctrl_q[CB_CTSEN] || (cts_in ^ ctrl_q[CB_CTSIV]);
    tx_trig_hit = (tx_lvl <= tx_trig_of(ctrl_q[1:0]));
    rx_trig_hit = (rx_lvl >= rx_trig_of(ctrl_q[4:2]));
    tmo_hit     = (ctrl_q[CB_TMO +: 2] != 2'd0) && !rx_empty &&
                  (idle_q >= tmo_lim_of(ctrl_q[CB_TMO +: 2]));
    ovr_set     = frame_vld && rx_full;
    tx_set      = tx_pop && ((tx_lvl - LVL_W'(1)) == tx_trig_of(ctrl_q[1:0]));

    ctrl_d = wr_ctrl ? bus_wdata[CTRL_W-1:0] : ctrl_q;
    rate_d = wr_rate ? bus_wdata[RATE_W-1:0] : rate_q;

    txs_d = tx_set    || (txs_q && !(wr_stat && bus_wdata[6]));
    ovr_d = ovr_set   || (ovr_q && !(wr_stat && bus_wdata[5]));
    brk_d = (frame_vld && frame.brk)  || (brk_q && !(wr_stat && bus_wdata[4]));
    fe_d  = (frame_vld && frame.ferr) || (fe_q  && !(wr_stat && bus_wdata[3]));

    if (frame_vld || rd_data) idle_d = '0;
    else if (bit_stb && idle_q != 8'hFF) idle_d = idle_q + 8'd1;
    else idle_d = idle_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rate_q <= '0;
      txs_q  <= 1'b0;
      ovr_q  <= 1'b0;
      brk_q  <= 1'b0;
      fe_q   <= 1'b0;
      idle_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      rate_q <= rate_d;
      txs_q  <= txs_d;
      ovr_q  <= ovr_d;
      brk_q  <= brk_d;
      fe_q   <= fe_d;
      idle_q <= idle_d;
    end
  end

  always_comb begin
    stat = {txs_q, ovr_q, brk_q, fe_q, tmo_hit, rx_trig_hit, tx_trig_hit};
    bus_rdata = '0;
    case (bus_addr)
      ADR_DATA:  bus_rdata = rx_empty ? 32'h100 :
                   {21'd0, rx_dout.brk, rx_dout.ferr, 1'b0, rx_dout.data};
      ADR_LEVEL: bus_rdata = {16'd0, tx_lvl, rx_lvl};
      ADR_STAT:  bus_rdata = {25'd0, stat};
      ADR_CTRL:  bus_rdata = {{(32-CTRL_W){1'b0}}, ctrl_q};
      ADR_RATE:  bus_rdata = {{(32-RATE_W){1'b0}}, rate_q};
      default:   bus_rdata = '0;
    endcase
    irq = (ctrl_q[CB_TXI] && txs_q) ||
          (ctrl_q[CB_RXI] && (rx_trig_hit || tmo_hit)) ||
          (ctrl_q[CB_ERRI] && (ovr_q || brk_q || fe_q));
    txd = ctrl_q[CB_BRK] ? 1'b0 : tx_line;
    rts_out = ctrl_q[CB_RTSEN] ?
              ((rx_lvl < rts_thr_of(ctrl_q[CB_RTSTH +: 2])) ^ ctrl_q[CB_RTSIV]) : 1'b1;
  end

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !(wr_stat && bus_wdata[5])) |=> ovr_q); // R5
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && bus_wdata[3] && !frame_vld) |=> !fe_q); // R6
  AST_NO_START_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !permit |-> !tx_pop); // R11
endmodule

// File: tb/osr14_uart_tb_top.sv
module osr14_uart_tb_top;
  localparam int CLK_NS = 10;
  localparam int DEPTH  = 8;
  localparam logic [2:0] A_DATA = 0, A_LVL = 1, A_STAT = 2, A_CTRL = 3, A_RATE = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0;
  logic [2:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic irq, txd, rts_out;
  logic rxd = 1'b1, cts_in = 1'b0;

  int n_chk = 0, n_bad = 0;
  int cur_rate = 0;
  bit mon_en = 1'b1;
  logic [31:0] ctrl_v = 0;
  logic [7:0] exp_q[$];

  always #(CLK_NS/2) clk = ~clk;

  osr14_uart #(.FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .txd(txd), .rxd(rxd), .cts_in(cts_in), .rts_out(rts_out));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic set_ctrl(input logic [31:0] v);
    ctrl_v = v;
    wr(A_CTRL, v);
  endtask

  // driver: queue the expected byte, then push it into the block
  task automatic tx_push(input logic [7:0] b, input bit expect_sent);
    if (expect_sent) exp_q.push_back(b);
    wr(A_DATA, {24'd0, b});
  endtask

  // serial frame into rxd; split: level flips after clock 5 of each data bit
  task automatic send(input logic [7:0] b, input logic stopv, input bit split);
    int per;
    per = 14 * (cur_rate + 1);
    @(negedge clk);
    rxd = 1'b0;
    repeat (per) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      if (split) begin
        repeat (6) @(negedge clk);
        rxd = ~b[i];
        repeat (per - 6) @(negedge clk);
      end else begin
        repeat (per) @(negedge clk);
      end
    end
    rxd = stopv;
    repeat (per) @(negedge clk);
    rxd = 1'b1;
    repeat (per) @(negedge clk);
  endtask

  // monitor: decode txd and compare against the queue
  initial begin
    forever begin
      logic [7:0] got;
      int per;
      @(negedge txd);
      if (mon_en) begin
        per = 14 * (cur_rate + 1);
        repeat (per / 2) @(posedge clk);
        #1;
        chk("R1 start bit", {31'd0, txd}, 32'd0);
        for (int i = 0; i < 8; i++) begin
          repeat (per) @(posedge clk);
          #1 got[i] = txd;
        end
        repeat (per) @(posedge clk);
        #1;
        chk("R1 stop bit", {31'd0, txd}, 32'd1);
        if (exp_q.size() == 0) chk("R1 unexpected frame", {24'd0, got}, 32'hFFFF_FFFF);
        else chk("R1 tx byte", {24'd0, got}, {24'd0, exp_q.pop_front()});
      end
    end
  end

  initial begin
    #(CLK_NS * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R14 reset state
    chk("R14 txd", {31'd0, txd}, 32'd1);
    chk("R14 rts_out", {31'd0, rts_out}, 32'd1);
    chk("R14 irq", {31'd0, irq}, 32'd0);
    rd(A_LVL, d);  chk("R14 level", d, 32'd0);
    rd(A_STAT, d); chk("R14 status", d, 32'h01);
    rd(A_DATA, d); chk("R14 R3 empty read", d, 32'h100);

    // CTS blocked: offset 6, rx trigger code 1 (4 entries)
    wr(A_RATE, 0); cur_rate = 0;
    set_ctrl((6 << 9) | (1 << 2) | (1 << 14));
    for (int i = 0; i < 3; i++) tx_push(8'h10 + 8'(i), 1);
    repeat (100) @(negedge clk);
    chk("R11 line idle while blocked", {31'd0, txd}, 32'd1);
    rd(A_LVL, d);  chk("R2 tx occupancy", d, 32'h0300);
    rd(A_STAT, d); chk("R8 tx trigger low", d & 32'h1, 32'h0);
    for (int i = 3; i < 8; i++) tx_push(8'h10 + 8'(i), 1);
    tx_push(8'hEE, 0);
    rd(A_LVL, d);  chk("R2 full write dropped", d, 32'h0800);

    // release CTS, drain
    cts_in = 1'b1;
    repeat (1500) @(negedge clk);
    chk("R1 all bytes sent", exp_q.size(), 0);
    rd(A_LVL, d);  chk("R2 tx drained", d, 32'h0);
    rd(A_STAT, d); chk("R8 tx set and trigger", d & 32'h41, 32'h41);
    set_ctrl(ctrl_v | (1 << 5));
    @(negedge clk);
    chk("R10 irq tx", {31'd0, irq}, 32'd1);
    wr(A_STAT, 32'h40);
    rd(A_STAT, d); chk("R6 clear tx set", d & 32'h40, 32'h0);
    chk("R10 irq cleared", {31'd0, irq}, 32'd0);

    // rate 1
    wr(A_RATE, 1); cur_rate = 1;
    tx_push(8'h3C, 1); tx_push(8'hC3, 1);
    repeat (800) @(negedge clk);
    chk("R1 rate 1 bytes sent", exp_q.size(), 0);
    wr(A_RATE, 0); cur_rate = 0;
    set_ctrl((6 << 9) | (1 << 2));

    // receive, rx trigger
    send(8'h11, 1, 0); send(8'h22, 1, 0); send(8'h33, 1, 0);
    rd(A_LVL, d);  chk("R2 rx occupancy", d, 32'h3);
    rd(A_STAT, d); chk("R7 below trigger", d & 32'h2, 32'h0);
    send(8'h44, 1, 0);
    rd(A_STAT, d); chk("R7 at trigger", d & 32'h2, 32'h2);
    for (int i = 0; i < 4; i++) begin
      rd(A_DATA, d); chk("R3 rx data", d, 32'h11 * (i + 1));
    end

    // sample offset
    set_ctrl((0 << 9) | (1 << 2));
    send(8'hA5, 1, 1);
    rd(A_DATA, d); chk("R3 offset 0", d, 32'hA5);
    set_ctrl((9 << 9) | (1 << 2));
    send(8'hA5, 1, 1);
    rd(A_DATA, d); chk("R3 offset 9", d, 32'h5A);
    set_ctrl((6 << 9) | (1 << 2) | (1 << 7));

    // framing error and break
    send(8'h55, 0, 0);
    rd(A_DATA, d); chk("R4 framing word", d, 32'h255);
    rd(A_STAT, d); chk("R4 framing status", d & 32'h18, 32'h08);
    chk("R10 irq error", {31'd0, irq}, 32'd1);
    send(8'h00, 0, 0);
    rd(A_DATA, d); chk("R4 break word", d, 32'h600);
    rd(A_STAT, d); chk("R4 break status", d & 32'h18, 32'h18);
    wr(A_STAT, 32'h18);
    rd(A_STAT, d); chk("R6 clear error bits", d & 32'h38, 32'h0);

    // overrun and RTS
    set_ctrl((6 << 9) | (1 << 2) | (1 << 18));
    chk("R12 rts ready", {31'd0, rts_out}, 32'd1);
    for (int i = 0; i < 9; i++) send(8'h80 + 8'(i), 1, 0);
    rd(A_STAT, d); chk("R5 overrun set", d & 32'h20, 32'h20);
    rd(A_LVL, d);  chk("R5 rx full", d, 32'h8);
    chk("R12 rts deasserted at 8", {31'd0, rts_out}, 32'd0);
    set_ctrl(ctrl_v | (1 << 21));
    @(negedge clk);
    chk("R12 rts inverted", {31'd0, rts_out}, 32'd1);
    for (int i = 0; i < 8; i++) begin
      rd(A_DATA, d); chk("R5 kept bytes", d, 32'h80 + i);
    end
    wr(A_STAT, 32'h20);
    rd(A_STAT, d); chk("R6 clear overrun", d & 32'h20, 32'h0);

    // timeout 4 characters
    set_ctrl((6 << 9) | (1 << 2) | (1 << 16));
    send(8'h5A, 1, 0);
    repeat (300) @(negedge clk);
    rd(A_STAT, d); chk("R9 timeout not yet", d & 32'h4, 32'h0);
    repeat (450) @(negedge clk);
    rd(A_STAT, d); chk("R9 timeout set", d & 32'h4, 32'h4);
    rd(A_DATA, d); chk("R9 byte", d, 32'h5A);
    rd(A_STAT, d); chk("R9 timeout gone", d & 32'h4, 32'h0);

    // forced break
    mon_en = 1'b0;
    set_ctrl(ctrl_v | (1 << 8));
    @(negedge clk);
    chk("R13 break low", {31'd0, txd}, 32'd0);
    set_ctrl(ctrl_v & ~(32'd1 << 8));
    @(negedge clk);
    chk("R13 break released", {31'd0, txd}, 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule